// File: doc/BRIEF.md
# Segment Privilege Check Unit

This unit rules on one protected-mode segment load at a time. The request names the kind of load, the current privilege level, the requested privilege carried in the selector, and the attributes of the descriptor. These attributes are its privilege level, whether it is code, conforming or readable, and, when the transfer goes through a gate, the gate's privilege level. One clock later the unit answers allow or fault, together with the privilege level that would be in force after the load. Table walks, limit checks, stack switching and gate traversal stay with the surrounding pipeline.

The comparison that applies depends on the kind of load and on the conforming bit:

- A plain jump to non-conforming code needs an exact level match.
- Calls through a gate, and transfers to conforming code, need the target to be at least as privileged as the reference level.
- Gated transfers also check the less privileged of the current and requested levels against the gate.
- Returns and task-switch code loads take their reference from the selector's requested level, and that level becomes the new current level.
- Data-register loads use the data-segment rule.

A two-state controller sequences the response. ST_IDLE moves to ST_RESP on a valid request. ST_RESP stays in ST_RESP when another request arrives, and returns to ST_IDLE when none does. While in ST_RESP, the completion output is high.

Top module: `spc_unit`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_done` high after the next rising edge, with exactly one of `rsp_allow` and `rsp_fault` high. In any cycle whose previous edge saw no valid request, `rsp_done`, `rsp_allow` and `rsp_fault` are all low.
- R2: While `rst_n` is low, and right after it is released, `rsp_done`, `rsp_allow`, `rsp_fault` and `rsp_pl` are all zero.
- R3: Jump (`req_kind` 0) to non-conforming code is allowed only when the descriptor level equals the current level. When `gate_used` is high, it also needs max(current, requested) ≤ `gate_dpl`.
- R4: Jump to conforming code is allowed only when the descriptor level ≤ the current level, plus the gate test when gated. Call (`req_kind` 1) through a gate needs descriptor level ≤ current level and max(current, requested) ≤ `gate_dpl`. Call without a gate follows the jump rules.
- R5: Far return or interrupt return (`req_kind` 2) compares against the selector's requested level. Conforming targets need descriptor level ≤ requested level, so requested 0 with descriptor 3 faults. Non-conforming targets need equality. `rsp_pl` becomes the requested level.
- R6: Task-switch code load (`req_kind` 4) uses the same rule as R5, and `rsp_pl` becomes the requested level of the incoming selector.
- R7: Data-register load (`req_kind` 3) of a data segment (`desc_code` 0) or of readable non-conforming code needs max(current, requested) ≤ descriptor level. Readable conforming code is always allowed. Execute-only code (`desc_code` 1, `desc_read` 0) always faults. `gate_used` has no effect.
- R8: The transfer kinds 0, 1, 2 and 4 fault when the descriptor is not code.
- R9: Kind codes 5 to 7 are reserved and always fault.
- R10: For kinds 0, 1, 3 and the reserved codes, `rsp_pl` equals the current level of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 jump, 1 call, 2 return, 3 data load, 4 task code load, 5-7 reserved |
| cur_pl | input | 2 | Current privilege level |
| sel_rpl | input | 2 | Requested level in the selector |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_code | input | 1 | Descriptor is a code segment |
| desc_conf | input | 1 | Code segment is conforming |
| desc_read | input | 1 | Code segment is readable |
| gate_used | input | 1 | Transfer goes through a gate |
| gate_dpl | input | 2 | Gate privilege level |
| rsp_done | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Load allowed |
| rsp_fault | output | 1 | General protection fault |
| rsp_pl | output | 2 | Resulting privilege level |

## Verification
Every verdict and the resulting level are due exactly one rising edge after the request is sampled. The bench therefore drives inputs on falling edges and reads outputs on the falling edge that follows the capturing edge. After each response it drops `req_valid` for one cycle and confirms that the outputs return to idle. A back-to-back case holds `req_valid` high across two edges and expects the second verdict in the second cycle, with no idle cycle between the two.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_JMP  = 3'd0,
        KIND_CALL = 3'd1,
        KIND_RET  = 3'd2,
        KIND_DATA = 3'd3,
        KIND_TASK = 3'd4
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } st_e;

    typedef struct packed {
        logic xfer;       // control transfer, target must be code
        logic data_ld;    // data register load rule
        logic rpl_ref;    // compare against selector level, not current
        logic gate_chk;   // apply the gate comparison
        logic call_gate;  // gated call: conforming-style test even if non-conforming
        logic pl_rpl;     // resulting level comes from the selector
        logic reserved;   // unknown kind code
    } ctrl_t;

endpackage

// File: rtl/spc_kind_decode.sv
module spc_kind_decode
    import spc_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              gate_used,
    output ctrl_t             ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (kind)
            KIND_JMP: begin
                ctrl.xfer     = 1'b1;
                ctrl.gate_chk = gate_used;
            end
            KIND_CALL: begin
                ctrl.xfer      = 1'b1;
                ctrl.gate_chk  = gate_used;
                ctrl.call_gate = gate_used;
            end
            KIND_RET: begin
                ctrl.xfer    = 1'b1;
                ctrl.rpl_ref = 1'b1;
                ctrl.pl_rpl  = 1'b1;
            end
            KIND_TASK: begin
                ctrl.xfer    = 1'b1;
                ctrl.rpl_ref = 1'b1;
                ctrl.pl_rpl  = 1'b1;
            end
            KIND_DATA: begin
                ctrl.data_ld = 1'b1;
            end
            default: begin
                ctrl.reserved = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/spc_pl_compare.sv
module spc_pl_compare
    import spc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  ctrl_t           ctrl,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] rpl,
    input  logic [PL_W-1:0] dpl,
    input  logic [PL_W-1:0] gdpl,
    input  logic            is_code,
    input  logic            is_conf,
    input  logic            is_read,
    output logic            allow,
    output logic [PL_W-1:0] next_pl
);

    logic [PL_W-1:0] eff_pl;
    logic [PL_W-1:0] ref_pl;
    logic            gate_ok;
    logic            exact_req;
    logic            xfer_ok;
    logic            data_ok;

    // numerically larger level is the less privileged one
    assign eff_pl    = (cpl > rpl) ? cpl : rpl;
    assign ref_pl    = ctrl.rpl_ref ? rpl : cpl;
    assign gate_ok   = !ctrl.gate_chk || (eff_pl <= gdpl);
    assign exact_req = !is_conf && !ctrl.call_gate;

    always_comb begin
        xfer_ok = 1'b0;
        if (is_code && gate_ok) begin
            if (exact_req) xfer_ok = (dpl == ref_pl);
            else           xfer_ok = (dpl <= ref_pl);
        end
    end

    always_comb begin
        if (!is_code)     data_ok = (eff_pl <= dpl);
        else if (!is_read) data_ok = 1'b0;
        else if (is_conf)  data_ok = 1'b1;
        else               data_ok = (eff_pl <= dpl);
    end

    always_comb begin
        if (ctrl.reserved)     allow = 1'b0;
        else if (ctrl.data_ld) allow = data_ok;
        else if (ctrl.xfer)    allow = xfer_ok;
        else                   allow = 1'b0;
    end

    assign next_pl = ctrl.pl_rpl ? rpl : cpl;

endmodule

// File: rtl/spc_unit.sv
module spc_unit
    import spc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [PL_W-1:0]   cur_pl,
    input  logic [PL_W-1:0]   sel_rpl,
    input  logic [PL_W-1:0]   desc_dpl,
    input  logic              desc_code,
    input  logic              desc_conf,
    input  logic              desc_read,
    input  logic              gate_used,
    input  logic [PL_W-1:0]   gate_dpl,
    output logic              rsp_done,
    output logic              rsp_allow,
    output logic              rsp_fault,
    output logic [PL_W-1:0]   rsp_pl
);

    ctrl_t           ctrl;
    logic            verdict;
    logic [PL_W-1:0] pl_calc;
    st_e             state_q;
    st_e             state_d;

    spc_kind_decode dec_i (
        .kind      (req_kind),
        .gate_used (gate_used),
        .ctrl      (ctrl)
    );

    spc_pl_compare #(.PL_W(PL_W)) cmp_i (
        .ctrl    (ctrl),
        .cpl     (cur_pl),
        .rpl     (sel_rpl),
        .dpl     (desc_dpl),
        .gdpl    (gate_dpl),
        .is_code (desc_code),
        .is_conf (desc_conf),
        .is_read (desc_read),
        .allow   (verdict),
        .next_pl (pl_calc)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_allow <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pl    <= '0;
        end else if (req_valid) begin
            rsp_allow <= verdict;
            rsp_fault <= !verdict;
            rsp_pl    <= pl_calc;
        end else begin
            rsp_allow <= 1'b0;
            rsp_fault <= 1'b0;
        end
    end

    assign rsp_done = (state_q == ST_RESP);

endmodule

// File: rtl/spc_unit_chk.sv
module spc_unit_chk
    import spc_pkg::*;
#(
    parameter int PL_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [KIND_W-1:0] req_kind,
    input logic [PL_W-1:0]   cur_pl,
    input logic [PL_W-1:0]   sel_rpl,
    input logic [PL_W-1:0]   desc_dpl,
    input logic              desc_code,
    input logic              desc_conf,
    input logic              desc_read,
    input logic              rsp_done,
    input logic              rsp_allow,
    input logic              rsp_fault,
    input logic [PL_W-1:0]   rsp_pl
);

    // R1
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);

    // R1
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_done && !rsp_allow && !rsp_fault));

    // R1
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_allow != rsp_fault));

    // R5
    ret_conf_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_RET && desc_code && desc_conf && desc_dpl > sel_rpl)
        |=> rsp_fault);

    // R6
    task_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == KIND_TASK || req_kind == KIND_RET))
        |=> (rsp_pl == $past(sel_rpl)));

    // R7
    exec_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_DATA && desc_code && !desc_read) |=> rsp_fault);

    // R8
    xfer_noncode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !desc_code && req_kind != KIND_DATA) |=> rsp_fault);

    // R9
    reserved_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind > KIND_TASK) |=> rsp_fault);

    // R10
    keep_pl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_TASK && req_kind != KIND_RET)
        |=> (rsp_pl == $past(cur_pl)));

endmodule

bind spc_unit spc_unit_chk #(.PL_W(PL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .cur_pl    (cur_pl),
    .sel_rpl   (sel_rpl),
    .desc_dpl  (desc_dpl),
    .desc_code (desc_code),
    .desc_conf (desc_conf),
    .desc_read (desc_read),
    .rsp_done  (rsp_done),
    .rsp_allow (rsp_allow),
    .rsp_fault (rsp_fault),
    .rsp_pl    (rsp_pl)
);

// File: tb/spc_unit_tb_top.sv
`timescale 1ns/1ps
module spc_unit_tb_top;

    localparam int PL_W  = 2;
    localparam int NVEC  = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_kind = '0;
    logic [PL_W-1:0] cur_pl = '0;
    logic [PL_W-1:0] sel_rpl = '0;
    logic [PL_W-1:0] desc_dpl = '0;
    logic            desc_code = 1'b0;
    logic            desc_conf = 1'b0;
    logic            desc_read = 1'b0;
    logic            gate_used = 1'b0;
    logic [PL_W-1:0] gate_dpl = '0;
    logic            rsp_done;
    logic            rsp_allow;
    logic            rsp_fault;
    logic [PL_W-1:0] rsp_pl;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    spc_unit #(.PL_W(PL_W)) dut_i (.*);

    // {kind, cpl, rpl, dpl, conf, read, code, gate, gdpl, exp_allow, exp_pl}
    localparam logic [17:0] VEC [NVEC] = '{
        {3'd0,2'd2,2'd2,2'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b1,2'd2}, // R3 exact match
        {3'd0,2'd2,2'd0,2'd1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd2}, // R3 mismatch
        {3'd0,2'd1,2'd3,2'd1,1'b0,1'b1,1'b1,1'b1,2'd2,1'b0,2'd1}, // R3 gate too privileged
        {3'd0,2'd1,2'd1,2'd1,1'b0,1'b1,1'b1,1'b1,2'd1,1'b1,2'd1}, // R3 gate ok
        {3'd0,2'd2,2'd0,2'd0,1'b1,1'b1,1'b1,1'b0,2'd0,1'b1,2'd2}, // R4 conforming up
        {3'd0,2'd1,2'd0,2'd3,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,2'd1}, // R4 conforming down
        {3'd1,2'd3,2'd3,2'd0,1'b0,1'b1,1'b1,1'b1,2'd3,1'b1,2'd3}, // R4 gated call
        {3'd1,2'd3,2'd0,2'd0,1'b0,1'b1,1'b1,1'b1,2'd2,1'b0,2'd3}, // R4 gate max
        {3'd1,2'd2,2'd2,2'd1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd2}, // R4 direct call
        {3'd2,2'd0,2'd0,2'd3,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,2'd0}, // R5 rpl0 dpl3
        {3'd2,2'd0,2'd3,2'd1,1'b1,1'b1,1'b1,1'b0,2'd0,1'b1,2'd3}, // R5 conforming ok
        {3'd2,2'd0,2'd2,2'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b1,2'd2}, // R5 exact
        {3'd2,2'd0,2'd2,2'd1,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd2}, // R5 mismatch
        {3'd4,2'd1,2'd0,2'd3,1'b1,1'b1,1'b1,1'b0,2'd0,1'b0,2'd0}, // R6 conforming reject
        {3'd4,2'd0,2'd3,2'd3,1'b0,1'b0,1'b1,1'b0,2'd0,1'b1,2'd3}, // R6 new level
        {3'd3,2'd1,2'd2,2'd2,1'b0,1'b0,1'b0,1'b0,2'd0,1'b1,2'd1}, // R7 data ok
        {3'd3,2'd0,2'd3,2'd2,1'b0,1'b0,1'b0,1'b0,2'd0,1'b0,2'd0}, // R7 data rpl weak
        {3'd3,2'd2,2'd0,2'd3,1'b0,1'b1,1'b1,1'b0,2'd0,1'b1,2'd2}, // R7 readable code
        {3'd3,2'd3,2'd0,2'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd3}, // R7 readable code cpl
        {3'd3,2'd3,2'd3,2'd0,1'b1,1'b1,1'b1,1'b0,2'd0,1'b1,2'd3}, // R7 conforming skip
        {3'd3,2'd0,2'd0,2'd3,1'b0,1'b0,1'b1,1'b0,2'd0,1'b0,2'd0}, // R7 execute-only
        {3'd0,2'd0,2'd0,2'd0,1'b0,1'b1,1'b0,1'b0,2'd0,1'b0,2'd0}, // R8 jump to data
        {3'd6,2'd2,2'd1,2'd2,1'b0,1'b1,1'b1,1'b0,2'd0,1'b0,2'd2}, // R9 reserved
        {3'd3,2'd1,2'd1,2'd2,1'b0,1'b0,1'b0,1'b1,2'd0,1'b1,2'd1}  // R7 gate ignored
    };

    task automatic check(input bit ok, input string req, input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic drive(input logic [17:0] v);
        req_valid = 1'b1;
        req_kind  = v[17:15];
        cur_pl    = v[14:13];
        sel_rpl   = v[12:11];
        desc_dpl  = v[10:9];
        desc_conf = v[8];
        desc_read = v[7];
        desc_code = v[6];
        gate_used = v[5];
        gate_dpl  = v[4:3];
    endtask

    task automatic expect_rsp(input logic [17:0] v, input int idx);
        check(rsp_done == 1'b1, $sformatf("R1 done vec%0d", idx), rsp_done, 1);
        check(rsp_allow == v[2] && rsp_fault == !v[2],
              $sformatf("verdict vec%0d kind%0d", idx, v[17:15]), rsp_allow, v[2]);
        check(rsp_pl == v[1:0], $sformatf("R10 level vec%0d", idx), rsp_pl, v[1:0]);
    endtask

    initial begin
        #4000000;
        n_fail++;
        n_run++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state while held
        check(rsp_done == 0 && rsp_allow == 0 && rsp_fault == 0 && rsp_pl == 0,
              "R2 in reset", {rsp_done, rsp_allow, rsp_fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_done == 0 && rsp_allow == 0 && rsp_fault == 0 && rsp_pl == 0,
              "R2 after release", {rsp_done, rsp_allow, rsp_fault}, 0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            expect_rsp(VEC[i], i);
            req_valid = 1'b0;
            @(negedge clk);
            // R1 idle after gap, level held
            check(rsp_done == 0 && rsp_allow == 0 && rsp_fault == 0,
                  "R1 idle", {rsp_done, rsp_allow, rsp_fault}, 0);
        end

        // R1 back-to-back requests
        drive(VEC[0]);
        @(negedge clk);
        expect_rsp(VEC[0], 0);
        drive(VEC[9]);
        @(negedge clk);
        expect_rsp(VEC[9], 9);
        drive(VEC[13]);
        @(negedge clk);
        expect_rsp(VEC[13], 13);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_done == 0, "R1 idle after burst", rsp_done, 0);

        // R2 reset during a response
        drive(VEC[10]);
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_done == 0 && rsp_allow == 0 && rsp_fault == 0 && rsp_pl == 0,
              "R2 mid-run reset", rsp_pl, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule